// File: doc/BRIEF.md
# Programmable Wait-State Acknowledge Generator

This block produces the acknowledge that closes each beat of an external bus transfer for a single chip-select region. A beat-start strobe loads a down-counter. The load value is either the initial wait count or a shorter secondary count. When the counter runs out, the block raises an internal acknowledge. The bus sequencer in front of it tells it whether the beat is the first beat and whether it is a read. The block uses this to pick the count.

Auto-acknowledge can be turned off. The block then never acknowledges by itself, and the beat stays open until external logic acknowledges. An external acknowledge always closes an open beat in the cycle it is seen, even while the internal count is still running.

Top module: `ws_ack_gen`

## Requirements
- R1: The initial wait field N (4 bits, 0 to 15) places the internal acknowledge in the (N+1)th cycle after the cycle in which `beat_start` is sampled high. `beat_done` is high in that same cycle.
- R2: For a read beat with `beat_first`=0 and auto-acknowledge on, the secondary field selects the wait count. Code 01 gives 0 waits, 10 gives 1 wait and 11 gives 2 waits. Code 00 falls back to the initial count.
- R3: Write beats, and the first beat of a read, always use the initial wait count, whatever the secondary field holds.
- R4: With `cfg_auto_ack`=0 sampled at beat start, `int_ack` never rises. The beat stays open for any number of cycles and ends in the first cycle in which `ext_ack` is high.
- R5: While a beat is open, `ext_ack` high ends it in that same cycle, even before the countdown expires. The beat then produces no further `int_ack` or `beat_done`.
- R6: `int_ack` and `beat_done` are each one clock wide for each beat.
- R7: `ext_ack` while no beat is open has no effect: `beat_done` stays low.
- R8: A synchronous active-high `rst` closes any open beat. After reset, `int_ack` and `beat_done` stay low until the next `beat_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init_waits | input | 4 | Initial wait states |
| cfg_sec_waits | input | 2 | Secondary read wait code (00 = off) |
| cfg_auto_ack | input | 1 | Enables the internal acknowledge |
| beat_start | input | 1 | One-cycle strobe that opens a beat |
| beat_first | input | 1 | 1 = first beat of the transfer |
| beat_read | input | 1 | 1 = read beat |
| ext_ack | input | 1 | External acknowledge |
| beat_done | output | 1 | Beat ends this cycle |
| int_ack | output | 1 | Internal acknowledge this cycle |

## Verification
The bench sweeps every initial count and every secondary code and measures the exact latency. An off-by-one counter shows up as a one-cycle shift, and a swapped secondary decode gives the wrong small latency. Writes and first read beats are run with the secondary field set. A selector that ignores the read or first flags would shorten these beats. An early external acknowledge on a long count must close the beat at once with no later internal acknowledge. With auto-acknowledge off the beat must stay open through a long idle stretch, so a design that still counted down would end it too soon. Reset in mid-count and stray external acknowledges while idle must leave the outputs quiet.

// File: rtl/ws_ack_pkg.sv
package ws_ack_pkg;
  localparam int INIT_W = 4;
  localparam int SEC_W  = 2;

  // Number of waits for one beat, given the configuration and beat kind.
  function automatic logic [INIT_W-1:0] pick_waits(
    input logic [INIT_W-1:0] init_w,
    input logic [SEC_W-1:0]  sec_code,
    input logic              auto_on,
    input logic              first,
    input logic              rd
  );
    if (auto_on && rd && !first && (sec_code != '0))
      return INIT_W'(sec_code - 1'b1);
    else
      return init_w;
  endfunction
endpackage

// File: rtl/ws_select.sv
module ws_select
  import ws_ack_pkg::*;
#(
  parameter int IW = INIT_W,
  parameter int SW = SEC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] init_w,
  input  logic [SW-1:0] sec_code,
  input  logic          auto_on,
  input  logic          first,
  input  logic          rd,
  output logic [IW-1:0] sel_waits,
  output logic          use_sec
);
  always_comb begin
    use_sec   = auto_on && rd && !first && (sec_code != '0);
    sel_waits = pick_waits(init_w, sec_code, auto_on, first, rd);
  end

  // R2: a secondary count never exceeds the largest secondary code minus one
  assert_sec_small_R2: assert property (@(posedge clk) disable iff (rst)
    use_sec |-> (sel_waits <= IW'((1 << SW) - 2)));
  // R3: write beats load the initial count
  assert_write_init_R3: assert property (@(posedge clk) disable iff (rst)
    !rd |-> (sel_waits == init_w));
endmodule

// File: rtl/ws_counter.sv
module ws_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          auto_in,
  input  logic          ext_ack,
  output logic          busy,
  output logic          int_ack,
  output logic          done,
  output logic [CW-1:0] cnt
);
  logic auto_q;
  logic expired;

  always_comb begin
    expired = busy && (cnt == '0);
    int_ack = expired && auto_q;
    done    = busy && (ext_ack || int_ack);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      auto_q <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      auto_q <= auto_in;
      cnt    <= load_val;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R1: an open beat counts down one step per cycle
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0 && !load && !done) |=> (cnt == $past(cnt) - 1'b1));
  // R5: a finished beat closes unless a new one is started
  assert_done_closes_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !busy);
  // R6: the internal acknowledge is a single-cycle pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !load) |=> !int_ack);
  // R8: reset leaves the counter idle
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!busy && !int_ack));
endmodule

// File: rtl/ws_ack_gen.sv
module ws_ack_gen
  import ws_ack_pkg::*;
#(
  parameter int IW = INIT_W,
  parameter int SW = SEC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] cfg_init_waits,
  input  logic [SW-1:0] cfg_sec_waits,
  input  logic          cfg_auto_ack,
  input  logic          beat_start,
  input  logic          beat_first,
  input  logic          beat_read,
  input  logic          ext_ack,
  output logic          beat_done,
  output logic          int_ack
);
  localparam int CW = IW;

  logic [CW-1:0] sel_waits;
  logic          use_sec;
  logic          busy_w;
  logic [CW-1:0] cnt_w;

  ws_select #(.IW(IW), .SW(SW)) u_sel (
    .clk(clk), .rst(rst),
    .init_w(cfg_init_waits), .sec_code(cfg_sec_waits),
    .auto_on(cfg_auto_ack), .first(beat_first), .rd(beat_read),
    .sel_waits(sel_waits), .use_sec(use_sec)
  );

  ws_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst),
    .load(beat_start), .load_val(sel_waits), .auto_in(cfg_auto_ack),
    .ext_ack(ext_ack),
    .busy(busy_w), .int_ack(int_ack), .done(beat_done), .cnt(cnt_w)
  );

  // R4: a beat opened with auto-acknowledge off never acknowledges internally
  assert_no_auto_R4: assert property (@(posedge clk) disable iff (rst)
    (beat_start && !cfg_auto_ack) |=> !int_ack);
  // R7: no beat end while idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_w |-> !beat_done);
  // R5: an external acknowledge on an open beat ends it
  assert_ext_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_w && ext_ack) |-> beat_done);
endmodule

// File: tb/ws_ack_gen_test.sv
module ws_ack_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cfg_init_waits = '0;
  logic [1:0] cfg_sec_waits = '0;
  logic cfg_auto_ack = 1'b1;
  logic beat_start = 1'b0, beat_first = 1'b1, beat_read = 1'b1, ext_ack = 1'b0;
  logic beat_done, int_ack;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ws_ack_gen uut (
    .clk(clk), .rst(rst), .cfg_init_waits(cfg_init_waits),
    .cfg_sec_waits(cfg_sec_waits), .cfg_auto_ack(cfg_auto_ack),
    .beat_start(beat_start), .beat_first(beat_first), .beat_read(beat_read),
    .ext_ack(ext_ack), .beat_done(beat_done), .int_ack(int_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected waits, from the requirement text.
  function automatic int model_waits(int init, int sec, bit auto_on, bit first, bit rd);
    if (auto_on && rd && !first && sec != 0) return sec - 1;
    return init;
  endfunction

  // Starts a beat and returns the cycles from the load to beat_done (-1 on timeout).
  task automatic run_beat(input int init, input int sec, input bit auto_on,
                          input bit first, input bit rd, output int lat, output bit ia);
    @(negedge clk);
    cfg_init_waits = 4'(init); cfg_sec_waits = 2'(sec); cfg_auto_ack = auto_on;
    beat_first = first; beat_read = rd; beat_start = 1'b1;
    @(negedge clk);
    beat_start = 1'b0;
    lat = 0;
    while (!beat_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    ia = int_ack;
    if (!beat_done) lat = -1;
  endtask

  task automatic t_reset_R8();
    check(beat_done == 0 && int_ack == 0, "R8 reset state", beat_done, 0);
  endtask

  task automatic t_initial_R1();
    int lat; bit ia;
    for (int n = 0; n < 16; n++) begin
      run_beat(n, 2, 1, 1, 1, lat, ia);
      check(lat == n, "R1 initial latency", lat, n);
      check(ia == 1, "R1 internal ack at end", ia, 1);
      @(negedge clk);
      check(int_ack == 0 && beat_done == 0, "R6 single pulse", int_ack + beat_done, 0);
    end
  endtask

  task automatic t_secondary_R2();
    int lat; bit ia;
    for (int s = 0; s < 4; s++) begin
      run_beat(9, s, 1, 0, 1, lat, ia);
      check(lat == model_waits(9, s, 1, 0, 1), "R2 secondary latency", lat,
            model_waits(9, s, 1, 0, 1));
    end
  endtask

  task automatic t_writes_R3();
    int lat; bit ia;
    run_beat(6, 3, 1, 0, 0, lat, ia);
    check(lat == 6, "R3 write later beat uses initial", lat, 6);
    run_beat(5, 1, 1, 1, 1, lat, ia);
    check(lat == 5, "R3 first read beat uses initial", lat, 5);
    run_beat(7, 2, 1, 1, 0, lat, ia);
    check(lat == 7, "R3 first write beat uses initial", lat, 7);
  endtask

  task automatic t_no_auto_R4();
    int seen = 0;
    @(negedge clk);
    cfg_init_waits = 4'd0; cfg_sec_waits = 2'd1; cfg_auto_ack = 1'b0;
    beat_first = 1'b0; beat_read = 1'b1; beat_start = 1'b1;
    @(negedge clk);
    beat_start = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (beat_done || int_ack) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R4 no end without ext ack", seen, 0);
    ext_ack = 1'b1;
    #1;
    check(beat_done == 1 && int_ack == 0, "R4 ext ack ends beat", beat_done, 1);
    @(negedge clk);
    ext_ack = 1'b0;
    #1;
    check(beat_done == 0, "R4 beat closed", beat_done, 0);
    cfg_auto_ack = 1'b1;
  endtask

  task automatic t_early_ext_R5();
    int seen = 0;
    @(negedge clk);
    cfg_init_waits = 4'd15; cfg_auto_ack = 1'b1;
    beat_first = 1'b1; beat_read = 1'b1; beat_start = 1'b1;
    @(negedge clk);
    beat_start = 1'b0;
    repeat (3) @(negedge clk);
    ext_ack = 1'b1;
    #1;
    check(beat_done == 1 && int_ack == 0, "R5 early ext ack ends beat", beat_done, 1);
    @(negedge clk);
    ext_ack = 1'b0;
    for (int i = 0; i < 25; i++) begin
      if (beat_done || int_ack) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R5 no later ack", seen, 0);
  endtask

  task automatic t_idle_ext_R7();
    int seen = 0;
    @(negedge clk);
    ext_ack = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (beat_done) seen++;
      @(negedge clk);
    end
    ext_ack = 1'b0;
    check(seen == 0, "R7 idle ext ack ignored", seen, 0);
  endtask

  task automatic t_reset_mid_R8();
    int seen = 0;
    @(negedge clk);
    cfg_init_waits = 4'd4; cfg_auto_ack = 1'b1;
    beat_first = 1'b1; beat_read = 1'b1; beat_start = 1'b1;
    @(negedge clk);
    beat_start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (beat_done || int_ack) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 reset aborts beat", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_R8();
    t_initial_R1();
    t_secondary_R2();
    t_writes_R3();
    t_no_auto_R4();
    t_early_ext_R5();
    t_idle_ext_R7();
    t_reset_mid_R8();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule